// File: doc/BRIEF.md
# Sixteen-bit multi-cycle register CPU core

This block is a small multi-cycle processor core. Data words, the eight general registers and the ALU are all sixteen bits wide. A single 256-word by 16-bit memory holds both the program and its data. The core steps through fetch, decode and execute states for each instruction and adds a memory state for loads and stores. It keeps one equality flag, which a compare sets and a conditional branch reads.

The program is supplied as a parameter vector and copied into the low memory words at start-up. Every other word starts at zero, so a program that runs past its last instruction fetches an all-zero word and stops. When the core stops it raises a halt output and holds its state. A register-observe port gives combinational read access to any register, so a testbench can compare final register contents against a reference result.

Top module: `cpu16_core`

## Requirements
- R1: Instruction word fields: bit 15 must be 0, bits 14:11 are the opcode, bits 10:8 are the destination register d, bits 7:5 are the source register s, and bits 7:0 are the 8-bit immediate. A fetched word with bit 15 set halts the core without executing.
- R2: While `rst` is high at a clock edge, the core clears the PC, all eight registers and the flag, and deasserts `halted`. After reset is released, fetching starts at address 0.
- R3: Register operations write d with the result of d op s, taken modulo 2^16. The codes are ADD 0000, SUB 0001, AND 0011, OR 0100 and XOR 0101. NOT (0010) writes the bitwise inverse of d and ignores s.
- R4: LSL (0110) and LSR (0111) shift d by the amount in s[3:0] and fill the vacated bits with zeros.
- R5: SUB and CMP (1000) set the flag to 1 exactly when d equals s, and to 0 otherwise. CMP writes no register. Every other instruction leaves the flag unchanged.
- R6: BEQ (1010) sets the PC to imm when the flag is 1, and to PC+1 when it is 0. BEQ writes no register and does not change the flag.
- R7: IMM (1011) writes d with imm zero-extended to 16 bits. For example, 0x580A loads 0x000A into r0.
- R8: LD (1100) loads d from memory address s[7:0]. ST (1101) writes d to memory address s[7:0]. A stored word is visible to later loads.
- R9: An instruction other than LD or ST takes 3 clock cycles, and LD or ST takes 4. Detecting a halting word takes 2 cycles, so `halted` rises 3N+4M+2 edges after reset is released.
- R10: The core halts on a fetched word of 0x0000, on a word with bit 15 set, or on opcode 1001, 1110 or 1111. It then asserts `halted` until reset, keeps the PC at the address of the halting word, and changes no register or flag.
- R11: Word i of the `PROG` parameter, at bits 16*i+15 down to 16*i, is the initial content of address i. All other addresses start at 0x0000.
- R12: `obs_data` shows register `obs_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| obs_sel | input | 3 | Register number to observe |
| obs_data | output | 16 | Contents of the observed register |
| eq_flag | output | 1 | Current equality flag |
| pc | output | 8 | Current program counter |
| halted | output | 1 | High once the core has stopped |

## Verification
On every cycle, the assertions check four things. Once halted, the core stays halted and its PC stays fixed. The PC does not move during fetch or decode. The flag changes only when SUB or CMP executes. Reset clears the PC, the flag and the state. The correctness of each opcode, the addressing that uses only the low eight bits of s, the branch targets, the loads of preloaded and stored words, and the exact cycle count to halt can only be shown by the bench. It runs six programs against an instruction-level model and compares every register, the flag, the PC and the edge count at which the core halts.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);
    localparam int MEM_DEPTH = 1 << ADDR_W;

    localparam logic [3:0] OP_ADD = 4'b0000;
    localparam logic [3:0] OP_SUB = 4'b0001;
    localparam logic [3:0] OP_NOT = 4'b0010;
    localparam logic [3:0] OP_AND = 4'b0011;
    localparam logic [3:0] OP_OR  = 4'b0100;
    localparam logic [3:0] OP_XOR = 4'b0101;
    localparam logic [3:0] OP_LSL = 4'b0110;
    localparam logic [3:0] OP_LSR = 4'b0111;
    localparam logic [3:0] OP_CMP = 4'b1000;
    localparam logic [3:0] OP_BEQ = 4'b1010;
    localparam logic [3:0] OP_IMM = 4'b1011;
    localparam logic [3:0] OP_LD  = 4'b1100;
    localparam logic [3:0] OP_ST  = 4'b1101;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_HALT
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   pc;
        logic [DATA_W-1:0]   ir;
        logic                flag;
    } core_st_t;
endpackage

// File: rtl/cpu16_alu.sv
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         same
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0] diff;

    always_comb begin
        diff = a - b;
        same = (diff == '0);
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = diff;
            OP_NOT:  y = ~a;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_LSL:  y = a << b[SH_W-1:0];
            OP_LSR:  y = a >> b[SH_W-1:0];
            default: y = a;
        endcase
    end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile
    import cpu16_pkg::*;
#(
    parameter int N  = NREG,
    parameter int W  = DATA_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [IW-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    input  logic [IW-1:0] ra_o,
    output logic [W-1:0]  rd_o
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    assign rd_a = regs_q[ra_a];
    assign rd_b = regs_q[ra_b];
    assign rd_o = regs_q[ra_o];
endmodule

// File: rtl/cpu16_ram.sv
module cpu16_ram
    import cpu16_pkg::*;
#(
    parameter int DEPTH      = MEM_DEPTH,
    parameter int W          = DATA_W,
    parameter int PROG_WORDS = 16,
    parameter logic [PROG_WORDS*W-1:0] PROG = '0,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = (i < PROG_WORDS) ? PROG[i*W +: W] : '0;
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int PROG_WORDS = 16,
    parameter logic [PROG_WORDS*DATA_W-1:0] PROG =
        {208'h0, 16'h1000, 16'h59AA, 16'h580A}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RIDX_W-1:0]   obs_sel,
    output logic [DATA_W-1:0]   obs_data,
    output logic                eq_flag,
    output logic [ADDR_W-1:0]   pc,
    output logic                halted
);
    core_st_t st_d, st_q;

    logic [3:0]        op;
    logic [RIDX_W-1:0] rd_idx, rs_idx;
    logic [7:0]        imm;
    logic [DATA_W-1:0] val_d, val_s, alu_y, ram_rdata, ram_wdata, rf_wdata;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we, rf_we, alu_same;

    assign op     = st_q.ir[14:11];
    assign rd_idx = st_q.ir[10:8];
    assign rs_idx = st_q.ir[7:5];
    assign imm    = st_q.ir[7:0];

    function automatic logic stops(input logic [DATA_W-1:0] w);
        return (w == '0) || w[15] || (w[14:11] == 4'b1001) || (w[14:12] == 3'b111);
    endfunction

    cpu16_regfile u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .waddr(rd_idx), .wdata(rf_wdata),
        .ra_a(rd_idx), .rd_a(val_d), .ra_b(rs_idx), .rd_b(val_s),
        .ra_o(obs_sel), .rd_o(obs_data)
    );

    cpu16_alu u_alu (.op(op), .a(val_d), .b(val_s), .y(alu_y), .same(alu_same));

    cpu16_ram #(.PROG_WORDS(PROG_WORDS), .PROG(PROG)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
    );

    always_comb begin
        st_d      = st_q;
        ram_addr  = st_q.pc;
        ram_we    = 1'b0;
        ram_wdata = val_d;
        rf_we     = 1'b0;
        rf_wdata  = alu_y;
        unique case (st_q.phase)
            ST_FETCH: st_d.phase = ST_DECODE;
            ST_DECODE: begin
                st_d.ir    = ram_rdata;
                st_d.phase = stops(ram_rdata) ? ST_HALT : ST_EXEC;
            end
            ST_EXEC: begin
                st_d.phase = ST_FETCH;
                st_d.pc    = st_q.pc + 1'b1;
                unique case (op)
                    OP_ADD, OP_NOT, OP_AND, OP_OR, OP_XOR, OP_LSL, OP_LSR:
                        rf_we = 1'b1;
                    OP_SUB: begin
                        rf_we     = 1'b1;
                        st_d.flag = alu_same;
                    end
                    OP_CMP: st_d.flag = alu_same;
                    OP_BEQ: if (st_q.flag) st_d.pc = imm;
                    OP_IMM: begin
                        rf_we    = 1'b1;
                        rf_wdata = {{(DATA_W-8){1'b0}}, imm};
                    end
                    OP_LD: begin
                        ram_addr   = val_s[ADDR_W-1:0];
                        st_d.pc    = st_q.pc;
                        st_d.phase = ST_MEM;
                    end
                    OP_ST: begin
                        ram_addr   = val_s[ADDR_W-1:0];
                        ram_we     = 1'b1;
                        st_d.pc    = st_q.pc;
                        st_d.phase = ST_MEM;
                    end
                    default: begin
                        st_d.pc    = st_q.pc;
                        st_d.phase = ST_HALT;
                    end
                endcase
            end
            ST_MEM: begin
                if (op == OP_LD) begin
                    rf_we    = 1'b1;
                    rf_wdata = ram_rdata;
                end
                st_d.pc    = st_q.pc + 1'b1;
                st_d.phase = ST_FETCH;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= ST_FETCH;
            st_q.pc    <= '0;
            st_q.ir    <= '0;
            st_q.flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eq_flag = st_q.flag;
    assign pc      = st_q.pc;
    assign halted  = (st_q.phase == ST_HALT);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.pc == '0 && st_q.phase == ST_FETCH && !st_q.flag));

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.phase == ST_HALT |=> (st_q.phase == ST_HALT && $stable(st_q.pc) && $stable(st_q.flag)));

    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !(st_q.phase == ST_EXEC && (op == OP_SUB || op == OP_CMP)) |=> $stable(st_q.flag));

    // R9
    pc_fetch_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == ST_FETCH || st_q.phase == ST_DECODE) |=> $stable(st_q.pc));
endmodule

// File: tb/tb_cpu16_core.sv
module tb_cpu16_core;
    import cpu16_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;
    localparam int NI = 6;

    function automatic logic [15:0] er(logic [3:0] o, int d, int s);
        return {1'b0, o, 3'(d), 3'(s), 5'b0};
    endfunction
    function automatic logic [15:0] ei(logic [3:0] o, int d, logic [7:0] v);
        return {1'b0, o, 3'(d), v};
    endfunction
    function automatic logic [PW*16-1:0] pack(logic [15:0] a [PW]);
        logic [PW*16-1:0] v;
        for (int i = 0; i < PW; i++) v[i*16 +: 16] = a[i];
        return v;
    endfunction

    localparam logic [15:0] A_ALU [PW] = '{
        ei(OP_IMM,0,8'hF0), ei(OP_IMM,1,8'h0F), ei(OP_IMM,2,8'h04), er(OP_ADD,0,1),
        ei(OP_IMM,3,8'hFF), er(OP_SUB,3,0),     er(OP_XOR,1,0),     er(OP_NOT,4,7),
        er(OP_LSR,4,2),     er(OP_LSL,0,2),     er(OP_OR,5,0),      er(OP_AND,4,1),
        er(OP_SUB,6,2),     er(OP_CMP,4,1),     ei(OP_IMM,7,8'h13), er(OP_LSL,2,7)};
    localparam logic [15:0] A_BR [PW] = '{
        ei(OP_IMM,0,8'h05), ei(OP_IMM,1,8'h01), ei(OP_IMM,2,8'h00), ei(OP_IMM,3,8'h00),
        er(OP_ADD,3,0),     er(OP_SUB,0,1),     ei(OP_BEQ,0,8'h09), er(OP_CMP,7,7),
        ei(OP_BEQ,0,8'h04), ei(OP_IMM,4,8'h77), 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
    localparam logic [15:0] A_MEM [PW] = '{
        ei(OP_IMM,0,8'h40), ei(OP_IMM,1,8'hC3), ei(OP_IMM,2,8'h08), er(OP_LSL,1,2),
        ei(OP_IMM,3,8'h5A), er(OP_OR,1,3),      er(OP_ST,1,0),      er(OP_LD,4,0),
        er(OP_ST,3,1),      er(OP_LD,2,3),      ei(OP_IMM,5,8'h01), er(OP_LD,6,5),
        ei(OP_IMM,7,8'hFF), er(OP_LD,7,7),      16'h0, 16'h0};
    localparam logic [15:0] A_BAD [PW] = '{
        ei(OP_IMM,0,8'h01), 16'h4C20, ei(OP_IMM,1,8'h05), 16'h0,
        16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
    localparam logic [15:0] A_B15 [PW] = '{
        ei(OP_IMM,2,8'h09), ei(OP_IMM,3,8'h03), 16'hD80A, ei(OP_IMM,1,8'h07),
        16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};
    localparam logic [15:0] A_HI [PW] = '{
        ei(OP_IMM,0,8'h02), er(OP_SUB,0,0), 16'h7FFF, ei(OP_IMM,6,8'h66),
        16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0};

    localparam logic [PW*16-1:0] P0 = pack(A_ALU);
    localparam logic [PW*16-1:0] P1 = pack(A_BR);
    localparam logic [PW*16-1:0] P2 = pack(A_MEM);
    localparam logic [PW*16-1:0] P3 = pack(A_BAD);
    localparam logic [PW*16-1:0] P4 = pack(A_B15);
    localparam logic [PW*16-1:0] P5 = pack(A_HI);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]  obs_sel = '0;
    logic [15:0] obs_w  [NI];
    logic        flag_w [NI];
    logic [7:0]  pc_w   [NI];
    logic        halt_w [NI];

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu16_core #(.PROG_WORDS(PW), .PROG(P0)) dut (.clk(clk), .rst(rst), .obs_sel(obs_sel),
        .obs_data(obs_w[0]), .eq_flag(flag_w[0]), .pc(pc_w[0]), .halted(halt_w[0]));
    cpu16_core #(.PROG_WORDS(PW), .PROG(P1)) dut_br (.clk(clk), .rst(rst), .obs_sel(obs_sel),
        .obs_data(obs_w[1]), .eq_flag(flag_w[1]), .pc(pc_w[1]), .halted(halt_w[1]));
    cpu16_core #(.PROG_WORDS(PW), .PROG(P2)) dut_mem (.clk(clk), .rst(rst), .obs_sel(obs_sel),
        .obs_data(obs_w[2]), .eq_flag(flag_w[2]), .pc(pc_w[2]), .halted(halt_w[2]));
    cpu16_core #(.PROG_WORDS(PW), .PROG(P3)) dut_bad (.clk(clk), .rst(rst), .obs_sel(obs_sel),
        .obs_data(obs_w[3]), .eq_flag(flag_w[3]), .pc(pc_w[3]), .halted(halt_w[3]));
    cpu16_core #(.PROG_WORDS(PW), .PROG(P4)) dut_b15 (.clk(clk), .rst(rst), .obs_sel(obs_sel),
        .obs_data(obs_w[4]), .eq_flag(flag_w[4]), .pc(pc_w[4]), .halted(halt_w[4]));
    cpu16_core #(.PROG_WORDS(PW), .PROG(P5)) dut_hi (.clk(clk), .rst(rst), .obs_sel(obs_sel),
        .obs_data(obs_w[5]), .eq_flag(flag_w[5]), .pc(pc_w[5]), .halted(halt_w[5]));

    // Instruction-level reference: registers, flag, halting PC and edge count to halt.
    function automatic void model(input logic [PW*16-1:0] prog, output logic [15:0] r [8],
                                  output logic f, output logic [7:0] p, output int cyc);
        logic [15:0] m [256];
        logic [15:0] w, a, b;
        logic [3:0]  o;
        int d, s;
        for (int i = 0; i < 256; i++) m[i] = (i < PW) ? prog[i*16 +: 16] : 16'h0;
        for (int i = 0; i < 8; i++) r[i] = 16'h0;
        f = 1'b0; p = 8'h0; cyc = 0;
        for (int step = 0; step < 2000; step++) begin
            w = m[p]; o = w[14:11]; d = int'(w[10:8]); s = int'(w[7:5]);
            if (w == 16'h0 || w[15] || o == 4'd9 || o >= 4'd14) begin
                cyc += 2;
                return;
            end
            a = r[d]; b = r[s]; cyc += 3;
            case (o)
                4'd0:  r[d] = a + b;
                4'd1:  begin r[d] = a - b; f = (a == b); end
                4'd2:  r[d] = ~a;
                4'd3:  r[d] = a & b;
                4'd4:  r[d] = a | b;
                4'd5:  r[d] = a ^ b;
                4'd6:  r[d] = a << b[3:0];
                4'd7:  r[d] = a >> b[3:0];
                4'd8:  f = (a == b);
                4'd11: r[d] = {8'h00, w[7:0]};
                4'd12: begin r[d] = m[b[7:0]]; cyc += 1; end
                4'd13: begin m[b[7:0]] = a; cyc += 1; end
                default: ;
            endcase
            p = (o == 4'd10 && f) ? w[7:0] : p + 8'd1;
        end
        cyc = -1;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(int k);
        case (k)
            0: return "R3 R4 R5 R7 R12";
            1: return "R5 R6";
            2: return "R8 R11";
            3: return "R10";
            4: return "R1 R10";
            default: return "R10";
        endcase
    endfunction

    initial begin
        logic [PW*16-1:0] progs [NI];
        logic [15:0] er_r [8];
        logic        e_f;
        logic [7:0]  e_p;
        int          e_c;
        int          halt_at [NI];
        int          cnt;
        logic        all_h;
        progs = '{P0, P1, P2, P3, P4, P5};
        for (int k = 0; k < NI; k++) halt_at[k] = -1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state on every instance
        for (int k = 0; k < NI; k++) begin
            chk("R2", "pc", 32'(pc_w[k]), 32'h0);
            chk("R2", "halted", 32'(halt_w[k]), 32'h0);
            chk("R2", "flag", 32'(flag_w[k]), 32'h0);
            for (int s = 0; s < 8; s++) begin
                obs_sel = 3'(s);
                #1;
                chk("R2 R12", "reg", 32'(obs_w[k]), 32'h0);
            end
        end
        rst = 1'b0;

        cnt = 0;
        all_h = 1'b0;
        while (!all_h && cnt < 3000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            all_h = 1'b1;
            for (int k = 0; k < NI; k++) begin
                if (halt_w[k] && halt_at[k] < 0) halt_at[k] = cnt;
                if (!halt_w[k]) all_h = 1'b0;
            end
        end
        if (!all_h) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=%0d expected=halt", cnt);
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < NI; k++) begin
            model(progs[k], er_r, e_f, e_p, e_c);
            // R9: edges from reset release to halt
            chk("R9", "cycles", 32'(halt_at[k]), 32'(e_c));
            chk(tag_of(k), "flag", 32'(flag_w[k]), 32'(e_f));
            chk(tag_of(k), "halt pc", 32'(pc_w[k]), 32'(e_p));
            chk("R10", "halted", 32'(halt_w[k]), 32'h1);
            for (int s = 0; s < 8; s++) begin
                obs_sel = 3'(s);
                #1;
                chk(tag_of(k), $sformatf("inst%0d r%0d", k, s), 32'(obs_w[k]), 32'(er_r[s]));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule